// File: doc/BRIEF.md
# Transactional Access Trigger Controller

This memory-stage control block decides, for each load or store in flight, whether the access must be diverted to a transactional bookkeeping handler before it is allowed to complete. It combines four inputs. The first is a mode bit that segment-start and segment-end opcodes switch on and off. The second is the shared-page bit that the translation lookaside buffer returns for the access. The third is the hit result of a stripe cache, which records the stripes already touched with the same access type. The fourth is the prediction made at fetch time for this instruction.

When the block diverts an access, it aborts that access and latches the access address and the instruction PC into dedicated save registers. It also issues an insert request to the stripe cache and an update request to the prediction table. If the prediction at fetch time missed the divert, the block also pulses a pipeline flush and redirects fetch to a fixed handler base address. If the divert was predicted, fetch is already in the handler and no flush is needed. When the handler signals that it is returning, fetch is redirected to the saved PC, so the aborted access executes again. Diverts are suppressed while the handler runs.

Top module: `txgate_ctrl`

## Requirements
- R1: `trig_o` is high in the same cycle as an access exactly when all of these hold: `acc_valid_i` is 1, triggering is enabled, the handler is not active, `shared_i` is 1 (1 = shared page, 0 = private page), and `sc_hit_i` is 0.
- R2: After reset, triggering is disabled. A `seg_start_i` pulse enables triggering from the next cycle on. A `seg_end_i` pulse disables it from the next cycle on. When both pulses arrive in the same cycle, triggering ends up disabled.
- R3: In the cycle after a trigger, `save_addr_o` holds that access's address and `save_pc_o` holds its PC. In every other cycle, both registers keep their values.
- R4: A trigger with `pred_i` = 0 raises `flush_o` and `redirect_o` for that single cycle, with `redirect_pc_o` = `HANDLER_BASE`.
- R5: A trigger with `pred_i` = 1 raises neither `flush_o` nor `redirect_o`.
- R6: Every trigger raises `sc_ins_o` and `pt_upd_o` in the same cycle, with these values: `sc_stripe_o` = address >> `STRIPE_LG`, `sc_write_o` = 1 for a store and 0 for a load, `pt_pc_o` = the PC, and `pt_pred_o` = `pred_i`. Neither request is raised without a trigger.
- R7: The handler is active from the cycle after a trigger until the cycle after an accepted return. While the handler is active, no access triggers.
- R8: A `ret_i` pulse while the handler is active raises `redirect_o` for one cycle with `redirect_pc_o` = the saved PC, and `flush_o` stays low. A `ret_i` pulse while the handler is idle has no effect.
- R9: Reset clears every pulse output, disables triggering, makes the handler idle, and sets both save registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_start_i | input | 1 | Segment-start opcode retired |
| seg_end_i | input | 1 | Segment-end opcode retired |
| ret_i | input | 1 | Handler return request |
| acc_valid_i | input | 1 | A load or store is in the memory stage |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| shared_i | input | 1 | Shared-page bit from the TLB |
| sc_hit_i | input | 1 | Stripe cache holds this stripe and access type |
| pred_i | input | 1 | A trigger was predicted at fetch |
| addr_i | input | AW | Access address |
| pc_i | input | PCW | Instruction PC |
| trig_o | output | 1 | Access is aborted and diverted |
| flush_o | output | 1 | Pipeline flush pulse |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | PCW | Fetch redirect target |
| sc_ins_o | output | 1 | Stripe cache insert request |
| sc_stripe_o | output | AW-STRIPE_LG | Stripe number to insert |
| sc_write_o | output | 1 | Access type to insert |
| pt_upd_o | output | 1 | Prediction table update request |
| pt_pc_o | output | PCW | PC of the entry to update |
| pt_pred_o | output | 1 | Whether the trigger was predicted |
| save_addr_o | output | AW | Saved access address |
| save_pc_o | output | PCW | Saved instruction PC |
| hnd_active_o | output | 1 | Handler in progress |

## Verification
The bench targets several corner cases:
- Access while disabled: a shared, uncached access made before any segment start, or after a segment end, must not trigger. A controller that ignored the mode bit would divert accesses outside segments.
- Start and end together: a segment start and a segment end in the same cycle must leave triggering off. A design that gave the start priority would trigger on the following access.
- Access during the handler: an access that arrives while the handler runs must not trigger. A design without this suppression would overwrite the saved PC, so the return redirect would land in the wrong place.
- Stray return: a return with no handler running must not redirect.
- Predicted and mispredicted triggers: these are checked in turn to catch a flush on a predicted trigger, or a redirect target other than the handler base.

// File: rtl/txgate_pkg.sv
package txgate_pkg;

    // Outcome of the memory-stage decision for one access.
    typedef enum logic [1:0] {
        DEC_PASS      = 2'd0,  // access proceeds normally
        DEC_HIT_PRED  = 2'd1,  // diverted, fetch already went to handler
        DEC_HIT_MISS  = 2'd2   // diverted, prediction missed: flush + redirect
    } dec_t;

    // Mode state carried between the mode tracker and the rest.
    typedef struct packed {
        logic enabled;
        logic hnd_active;
    } mode_t;

    function automatic logic dec_is_trig(input dec_t d);
        return (d == DEC_HIT_PRED) || (d == DEC_HIT_MISS);
    endfunction

    function automatic logic dec_is_miss(input dec_t d);
        return d == DEC_HIT_MISS;
    endfunction

endpackage

// File: rtl/txgate_mode.sv
module txgate_mode
    import txgate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seg_start_i,
    input  logic  seg_end_i,
    input  logic  trig_i,
    input  logic  ret_i,
    output mode_t mode_o,
    output logic  ret_take_o
);

    mode_t mode_q;

    // A return counts only when a handler is running.
    assign ret_take_o = ret_i && mode_q.hnd_active;
    assign mode_o     = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            // End wins over start when both retire together.
            if (seg_end_i)
                mode_q.enabled <= 1'b0;
            else if (seg_start_i)
                mode_q.enabled <= 1'b1;

            if (trig_i)
                mode_q.hnd_active <= 1'b1;
            else if (ret_take_o)
                mode_q.hnd_active <= 1'b0;
        end
    end

    AST_END_DISABLES: assert property (@(posedge clk) disable iff (rst)
        seg_end_i |=> !mode_q.enabled);  // R2

    AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (seg_start_i && !seg_end_i) |=> mode_q.enabled);  // R2

    AST_HANDLER_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> mode_q.hnd_active);  // R7

    AST_RET_ENDS_HANDLER: assert property (@(posedge clk) disable iff (rst)
        ret_take_o |=> !mode_q.hnd_active);  // R8

endmodule

// File: rtl/txgate_decide.sv
module txgate_decide
    import txgate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode_i,
    input  logic  acc_valid_i,
    input  logic  shared_i,
    input  logic  sc_hit_i,
    input  logic  pred_i,
    output dec_t  dec_o
);

    logic eligible;

    always_comb begin
        eligible = acc_valid_i && mode_i.enabled && !mode_i.hnd_active
                   && shared_i && !sc_hit_i;
        if (!eligible)
            dec_o = DEC_PASS;
        else if (pred_i)
            dec_o = DEC_HIT_PRED;
        else
            dec_o = DEC_HIT_MISS;
    end

    AST_NO_TRIG_IN_HANDLER: assert property (@(posedge clk) disable iff (rst)
        mode_i.hnd_active |-> dec_o == DEC_PASS);  // R7

    AST_NO_TRIG_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !mode_i.enabled |-> dec_o == DEC_PASS);  // R1

endmodule

// File: rtl/txgate_ctxregs.sv
module txgate_ctxregs #(
    parameter int AW  = 32,
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [PCW-1:0] pc_i,
    output logic [AW-1:0]  addr_o,
    output logic [PCW-1:0] pc_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            pc_o   <= '0;
        end else if (load_i) begin
            addr_o <= addr_i;
            pc_o   <= pc_i;
        end
    end

    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(addr_i)) && (pc_o == $past(pc_i)));  // R3

    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(addr_o) && $stable(pc_o));  // R3

endmodule

// File: rtl/txgate_ctrl.sv
module txgate_ctrl
    import txgate_pkg::*;
#(
    parameter int              AW           = 32,
    parameter int              PCW          = 32,
    parameter int              STRIPE_LG    = 6,
    parameter logic [PCW-1:0]  HANDLER_BASE = 32'h0000_8000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  seg_start_i,
    input  logic                  seg_end_i,
    input  logic                  ret_i,
    input  logic                  acc_valid_i,
    input  logic                  acc_store_i,
    input  logic                  shared_i,
    input  logic                  sc_hit_i,
    input  logic                  pred_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [PCW-1:0]        pc_i,
    output logic                  trig_o,
    output logic                  flush_o,
    output logic                  redirect_o,
    output logic [PCW-1:0]        redirect_pc_o,
    output logic                  sc_ins_o,
    output logic [AW-STRIPE_LG-1:0] sc_stripe_o,
    output logic                  sc_write_o,
    output logic                  pt_upd_o,
    output logic [PCW-1:0]        pt_pc_o,
    output logic                  pt_pred_o,
    output logic [AW-1:0]         save_addr_o,
    output logic [PCW-1:0]        save_pc_o,
    output logic                  hnd_active_o
);

    localparam int SW = AW - STRIPE_LG;

    mode_t mode;
    dec_t  dec;
    logic  ret_take;
    logic  trig;
    logic  miss;

    txgate_decide u_decide (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .acc_valid_i (acc_valid_i),
        .shared_i    (shared_i),
        .sc_hit_i    (sc_hit_i),
        .pred_i      (pred_i),
        .dec_o       (dec)
    );

    assign trig = dec_is_trig(dec);
    assign miss = dec_is_miss(dec);

    txgate_mode u_mode (
        .clk         (clk),
        .rst         (rst),
        .seg_start_i (seg_start_i),
        .seg_end_i   (seg_end_i),
        .trig_i      (trig),
        .ret_i       (ret_i),
        .mode_o      (mode),
        .ret_take_o  (ret_take)
    );

    txgate_ctxregs #(.AW(AW), .PCW(PCW)) u_ctx (
        .clk    (clk),
        .rst    (rst),
        .load_i (trig),
        .addr_i (addr_i),
        .pc_i   (pc_i),
        .addr_o (save_addr_o),
        .pc_o   (save_pc_o)
    );

    always_comb begin
        trig_o        = trig;
        flush_o       = miss;
        redirect_o    = miss || ret_take;
        redirect_pc_o = miss ? HANDLER_BASE : save_pc_o;
        sc_ins_o      = trig;
        sc_stripe_o   = addr_i[AW-1:STRIPE_LG];
        sc_write_o    = acc_store_i;
        pt_upd_o      = trig;
        pt_pc_o       = pc_i;
        pt_pred_o     = pred_i;
        hnd_active_o  = mode.hnd_active;
    end

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);  // R4

    AST_PRED_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (trig_o && pred_i) |-> !flush_o && !redirect_o);  // R5

    AST_TABLES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        sc_ins_o |-> pt_upd_o);  // R6

    AST_TRIG_NEEDS_SHARED: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> shared_i && !sc_hit_i && acc_valid_i);  // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !hnd_active_o && save_pc_o == '0);  // R9

endmodule

// File: tb/txgate_ctrl_test.sv
module txgate_ctrl_test;

    localparam int AW = 32;
    localparam int PCW = 32;
    localparam int SLG = 6;
    localparam logic [PCW-1:0] BASE = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seg_start_i = 0, seg_end_i = 0, ret_i = 0;
    logic acc_valid_i = 0, acc_store_i = 0, shared_i = 0, sc_hit_i = 0, pred_i = 0;
    logic [AW-1:0]  addr_i = '0;
    logic [PCW-1:0] pc_i = '0;
    logic trig_o, flush_o, redirect_o, sc_ins_o, sc_write_o, pt_upd_o, pt_pred_o, hnd_active_o;
    logic [PCW-1:0] redirect_pc_o, pt_pc_o, save_pc_o;
    logic [AW-SLG-1:0] sc_stripe_o;
    logic [AW-1:0] save_addr_o;

    always #5 clk = ~clk;

    txgate_ctrl #(.AW(AW), .PCW(PCW), .STRIPE_LG(SLG), .HANDLER_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .seg_start_i(seg_start_i), .seg_end_i(seg_end_i),
        .ret_i(ret_i), .acc_valid_i(acc_valid_i), .acc_store_i(acc_store_i),
        .shared_i(shared_i), .sc_hit_i(sc_hit_i), .pred_i(pred_i),
        .addr_i(addr_i), .pc_i(pc_i), .trig_o(trig_o), .flush_o(flush_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .sc_ins_o(sc_ins_o),
        .sc_stripe_o(sc_stripe_o), .sc_write_o(sc_write_o), .pt_upd_o(pt_upd_o),
        .pt_pc_o(pt_pc_o), .pt_pred_o(pt_pred_o), .save_addr_o(save_addr_o),
        .save_pc_o(save_pc_o), .hnd_active_o(hnd_active_o)
    );

    typedef struct packed {
        logic st; logic en; logic rt; logic v; logic w; logic sh; logic hit; logic pr;
        logic [15:0] a; logic [15:0] p;
        logic et; logic ef; logic er;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // st en rt v  w  sh hit pr addr      pc       trig flush redir
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h1000,16'h0100,1'b0,1'b0,1'b0}, // disabled
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0}, // start
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h1040,16'h0200,1'b1,1'b1,1'b1}, // miss trig
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h3000,16'h0900,1'b0,1'b0,1'b0}, // in handler
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b1}, // return
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h1040,16'h0200,1'b0,1'b0,1'b0}, // cache hit
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h2084,16'h0204,1'b1,1'b0,1'b0}, // pred trig
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b1}, // return
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h5000,16'h0400,1'b0,1'b0,1'b0}, // private
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0}, // stray ret
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h6000,16'h0500,1'b0,1'b0,1'b0}, // no valid
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0}, // end
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h7000,16'h0600,1'b0,1'b0,1'b0}, // after end
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0}, // both
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h7100,16'h0610,1'b0,1'b0,1'b0}, // still off
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0}, // start
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hFFC0,16'h0300,1'b1,1'b1,1'b1}  // miss store
    };

    int checks = 0;
    int errors = 0;
    logic [AW-1:0]  m_addr = '0;
    logic [PCW-1:0] m_pc = '0;
    bit done = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        seg_start_i = v.st; seg_end_i = v.en; ret_i = v.rt;
        acc_valid_i = v.v; acc_store_i = v.w; shared_i = v.sh;
        sc_hit_i = v.hit; pred_i = v.pr;
        addr_i = AW'(v.a); pc_i = PCW'(v.p);
    endtask

    task automatic idle();
        drive('0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 trig", 64'(trig_o), 64'd0);
        chk("R9 flush", 64'(flush_o), 64'd0);
        chk("R9 redirect", 64'(redirect_o), 64'd0);
        chk("R9 handler", 64'(hnd_active_o), 64'd0);
        chk("R9 save_addr", 64'(save_addr_o), 64'd0);
        chk("R9 save_pc", 64'(save_pc_o), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [PCW-1:0] erpc;
            v = VEC[i];
            @(negedge clk);
            drive(v);
            #1;
            erpc = v.rt ? m_pc : BASE;
            chk("R1 trig", 64'(trig_o), 64'(v.et));
            chk("R4 flush", 64'(flush_o), 64'(v.ef));
            chk("R8 redirect", 64'(redirect_o), 64'(v.er));
            if (v.er) chk("R4 redirect_pc", 64'(redirect_pc_o), 64'(erpc));
            chk("R6 sc_ins", 64'(sc_ins_o), 64'(v.et));
            chk("R6 pt_upd", 64'(pt_upd_o), 64'(v.et));
            if (v.et) begin
                chk("R6 stripe", 64'(sc_stripe_o), 64'(v.a) >> SLG);
                chk("R6 write", 64'(sc_write_o), 64'(v.w));
                chk("R6 pt_pc", 64'(pt_pc_o), 64'(v.p));
                chk("R5 pt_pred", 64'(pt_pred_o), 64'(v.pr));
                m_addr = AW'(v.a);
                m_pc = PCW'(v.p);
            end
            @(posedge clk);
            #1;
            chk("R3 save_addr", 64'(save_addr_o), 64'(m_addr));
            chk("R3 save_pc", 64'(save_pc_o), 64'(m_pc));
        end

        // R7: handler active after trigger of last vector
        @(negedge clk);
        idle();
        chk("R7 handler active", 64'(hnd_active_o), 64'd1);

        // R9: reset mid-handler clears mode and saved state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 handler cleared", 64'(hnd_active_o), 64'd0);
        chk("R9 save_pc cleared", 64'(save_pc_o), 64'd0);
        acc_valid_i = 1; shared_i = 1; addr_i = 32'h40; pc_i = 32'h44;
        #1;
        chk("R2 disabled after reset", 64'(trig_o), 64'd0);
        @(posedge clk);
        #1;
        chk("R3 hold without trigger", 64'(save_addr_o), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule